// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one 32-bit countdown timer channel controlled through a small word-indexed register port. Software loads a reload value and a starting count, picks one of five prescale ratios of the peripheral clock and raises the run input. The counter then steps down once per prescaled tick. When a tick lands on a count of zero, the counter is refilled from the reload register and an underflow flag is set. The flag drives the interrupt output whenever the interrupt-enable bit is on, and software clears it by writing zero to it.

Capture and external clocking are not built. Their control fields are still decoded, and any value that would need them raises a sticky configuration-error output, as does any access to the capture slot. The counter read is combinational, so a read strobe returns the count held in that same cycle.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the reload register and the counter both read 0xFFFFFFFF, the control register reads 0, and irq and cfg_err are low.
- R2: reg_idx selects the register: 0 is reload, 1 is counter, 2 is control, 3 is capture. reg_rdata shows the selected value in the same cycle that reg_rd is high, and it is 0 when reg_rd is low.
- R3: Control bits [2:0] hold a rate code s from 0 to 4, which gives a tick every 4<<(2*s) clocks (4, 16, 64, 256 or 1024). The prescaler counts only while run_en is high and restarts from zero on every control write. With run_en held high, the first tick after a control write comes on the clock edge 4<<(2*s) edges after that write.
- R4: On a tick the counter decrements. A tick at a count of 0 instead loads the reload value and sets the underflow flag.
- R5: A counter write loads the count at once and wins over a tick in the same cycle. A reload write changes only the value used at later underflows.
- R6: A control write stores bits [15:0] with bits 8 and 9 forced to 0. A control read returns the stored bits, with bit 8 replaced by the live underflow flag and bits [31:16] as 0.
- R7: A control write with bit 8 at 0 clears the flag, and one with bit 8 at 1 leaves it as it was. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: irq is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R9: cfg_err is set and stays set until reset when a control write carries a rate code of 5, 6 or 7, nonzero bits [4:3], nonzero bits [7:6], bit 9 set, or any of bits [31:10] set. A control write that has none of these leaves cfg_err low.
- R10: Any read or write at index 3 sets cfg_err. A capture read returns 0, and a capture write changes no other register.
- R11: While run_en is low the counter holds its value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_idx | input | 2 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| run_en | input | 1 | Channel run enable |
| irq | output | 1 | Underflow interrupt |
| cfg_err | output | 1 | Sticky illegal-configuration indicator |

## Verification
The slowest rate is driven from a known counter value with the count read every cycle. This separates a correct 1024-clock spacing from off-by-one prescaler restarts. Short reload and count values at the fastest rates force frequent underflows, so a wrong reload source, a lost flag or ungated interrupts show up within a few ticks. A random mix of register writes, reads and run toggles lands clearing writes on underflow cycles and counter writes on tick cycles, which exercises the priority rules. Directed illegal control values and capture accesses, each following a fresh reset, confirm which encodings raise the sticky error and which do not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int PRE_W    = 10;
  localparam int DIV_W    = PRE_W + 1;
  localparam int CTRL_W   = 16;
  localparam logic [2:0] RATE_MAX = 3'd4;

  typedef enum logic [1:0] {
    IDX_RELOAD = 2'd0,
    IDX_COUNT  = 2'd1,
    IDX_CTRL   = 2'd2,
    IDX_CAPT   = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic [5:0] rsvd;
    logic       capt_flag;
    logic       uf_flag;
    logic [1:0] capt_edge;
    logic       uf_ie;
    logic [1:0] clk_edge;
    logic [2:0] rate_sel;
  } ctrl_t;

  function automatic logic rate_legal(input logic [2:0] sel);
    return sel <= RATE_MAX;
  endfunction

  // Clocks per tick: 4 shifted left by twice the rate code
  function automatic logic [DIV_W-1:0] rate_div(input logic [2:0] sel);
    logic [3:0] sh;
    sh = {sel, 1'b0};
    return DIV_W'(4) << sh;
  endfunction

  function automatic logic ctrl_illegal(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c = ctrl_t'(w[CTRL_W-1:0]);
    return !rate_legal(c.rate_sel) || (c.clk_edge != 2'b00) ||
           (c.capt_edge != 2'b00) || c.capt_flag || (|c.rsvd) ||
           (|w[DATA_W-1:CTRL_W]);
  endfunction

  function automatic ctrl_t ctrl_store(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c = ctrl_t'(w[CTRL_W-1:0]);
    c.uf_flag   = 1'b0;
    c.capt_flag = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       restart,
  input  logic [2:0] rate_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_w;

  assign div_w = rate_div(rate_sel);
  assign tick  = run_en && rate_legal(rate_sel) &&
                 ({1'b0, pre_q} == (div_w - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (run_en)  pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             uf_evt
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign uf_evt  = tick && !cnt_wr && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= RST_VAL;
      reload_q <= RST_VAL;
    end else begin
      if (rld_wr) reload_q <= wdata;
      if (cnt_wr)       cnt_q <= wdata;
      else if (tick)    cnt_q <= at_zero ? reload_q : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uf_evt,
  input  logic              capt_acc,
  output ctrl_t             ctrl_q,
  output logic              flag_q,
  output logic              err_q
);
  logic bad_wr;
  logic clr_req;

  assign bad_wr  = ctrl_wr && ctrl_illegal(wdata);
  assign clr_req = ctrl_wr && !wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_store(wdata);
      if (uf_evt)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (bad_wr || capt_acc) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              run_en,
  output logic              irq,
  output logic              cfg_err
);
  reg_idx_e   idx_w;
  logic       rld_wr_w, cnt_wr_w, ctrl_wr_w, capt_acc_w;
  logic       tick_w, uf_evt_w, flag_q, ie_w;
  ctrl_t      ctrl_q, ctrl_view;
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic [DATA_W-1:0] cnt_ext, rld_ext;

  assign idx_w      = reg_idx_e'(reg_idx);
  assign rld_wr_w   = reg_wr && (idx_w == IDX_RELOAD);
  assign cnt_wr_w   = reg_wr && (idx_w == IDX_COUNT);
  assign ctrl_wr_w  = reg_wr && (idx_w == IDX_CTRL);
  assign capt_acc_w = (reg_wr || reg_rd) && (idx_w == IDX_CAPT);

  tmr_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .restart  (ctrl_wr_w),
    .rate_sel (ctrl_q.rate_sel),
    .tick     (tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .cnt_wr   (cnt_wr_w),
    .rld_wr   (rld_wr_w),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .uf_evt   (uf_evt_w)
  );

  tmr_ctrl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr_w),
    .wdata    (reg_wdata),
    .uf_evt   (uf_evt_w),
    .capt_acc (capt_acc_w),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q),
    .err_q    (cfg_err)
  );

  generate
    if (CNT_W == DATA_W) begin : g_full
      assign cnt_ext = cnt_q;
      assign rld_ext = reload_q;
    end else begin : g_narrow
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      assign rld_ext = {{(DATA_W-CNT_W){1'b0}}, reload_q};
    end
  endgenerate

  always_comb begin
    ctrl_view         = ctrl_q;
    ctrl_view.uf_flag = flag_q;
  end

  assign ie_w = ctrl_q.uf_ie;
  assign irq  = flag_q && ie_w;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (idx_w)
        IDX_RELOAD: reg_rdata = rld_ext;
        IDX_COUNT:  reg_rdata = cnt_ext;
        IDX_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_view};
        IDX_CAPT:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             irq,
  input logic             cfg_err,
  input logic             tick,
  input logic             uf_evt,
  input logic             cnt_wr,
  input logic             flag_q,
  input logic             ie,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run_en);

  assert_underflow_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt_q == $past(reload_q)));

  assert_underflow_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flag_q);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_frozen_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt_q));
endmodule

bind reload_down_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .irq      (irq),
  .cfg_err  (cfg_err),
  .tick     (tick_w),
  .uf_evt   (uf_evt_w),
  .cnt_wr   (cnt_wr_w),
  .flag_q   (flag_q),
  .ie       (ie_w),
  .cnt_q    (cnt_q),
  .reload_q (reload_q)
);

// File: tb/sim_reload_down_timer.sv
`timescale 1ns/1ps
module sim_reload_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        run_en = 1'b0;
  logic        irq, cfg_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reload_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .run_en(run_en), .irq(irq), .cfg_err(cfg_err)
  );

  // Independent behavioural model
  logic [31:0] m_rld, m_cnt;
  logic [15:0] m_ctl;
  logic        m_flag, m_err;
  int          m_pre;

  function automatic int b_div(input logic [2:0] s);
    int d = 4;
    for (int k = 0; k < s; k++) d = d * 4;
    return d;
  endfunction

  function automatic bit b_bad(input logic [31:0] w);
    return (w[2:0] > 3'd4) || ((w & 32'hFFFF_FED8) != 0);
  endfunction

  function automatic logic [31:0] b_read(input logic [1:0] i);
    case (i)
      2'd0: return m_rld;
      2'd1: return m_cnt;
      2'd2: return {16'd0, m_ctl[15:9], m_flag, m_ctl[7:0]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rld = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_ctl = 16'd0;
      m_flag = 0; m_err = 0; m_pre = 0;
    end else begin
      bit tk, uf, wc, wn;
      wc = reg_wr && reg_idx == 2'd2;
      wn = reg_wr && reg_idx == 2'd1;
      tk = run_en && (m_ctl[2:0] <= 3'd4) && (m_pre == b_div(m_ctl[2:0]) - 1);
      uf = tk && !wn && (m_cnt == 0);
      if (wc || tk) m_pre = 0; else if (run_en) m_pre = (m_pre + 1) % 1024;
      if (wn) m_cnt = reg_wdata;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      if (reg_wr && reg_idx == 2'd0) m_rld = reg_wdata;
      if (uf) m_flag = 1; else if (wc && !reg_wdata[8]) m_flag = 0;
      if ((wc && b_bad(reg_wdata)) || ((reg_wr || reg_rd) && reg_idx == 2'd3)) m_err = 1;
      if (wc) m_ctl = reg_wdata[15:0] & 16'hFCFF;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: check irq/err, drive inputs, check read data
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] idx,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    check("R8 irq", {31'd0, irq}, {31'd0, m_flag & m_ctl[5]});
    check("R9 cfg_err", {31'd0, cfg_err}, {31'd0, m_err});
    reg_wr = wr; reg_rd = rd; reg_idx = idx; reg_wdata = d;
    #1;
    if (rd) check(tag, reg_rdata, b_read(idx));
    else    check("R2 idle read", reg_rdata, 32'd0);
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
    cyc(1, 0, idx, d, "");
  endtask

  task automatic rd_reg(input logic [1:0] idx, input string tag);
    cyc(0, 1, idx, 32'd0, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 2'd0, 32'd0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_wr = 0; reg_rd = 0; run_en = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R1 reset state
    rd_reg(2'd0, "R1 reload reset");
    rd_reg(2'd1, "R1 counter reset");
    rd_reg(2'd2, "R1 control reset");
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    check("R1 err reset", {31'd0, cfg_err}, 32'd0);

    // R3 slowest rate, prescaler restarted by the control write
    wr_reg(2'd2, 32'h0000_0004);
    wr_reg(2'd1, 32'd10);
    @(negedge clk); run_en = 1;
    for (int k = 0; k < 1100; k++) rd_reg(2'd1, "R3 rate 1024 count");
    begin
      // after 1100+ run edges exactly one tick: count is 9
      check("R3 one decrement", b_read(2'd1), 32'd9);
    end

    // R4 underflow and reload with interrupt enabled, fastest rate
    wr_reg(2'd0, 32'd5);
    wr_reg(2'd2, 32'h0000_0020);
    wr_reg(2'd1, 32'd2);
    for (int k = 0; k < 40; k++) rd_reg(2'd1, "R4 count/reload");
    rd_reg(2'd2, "R6 flag in control read");
    // R7 write-one keeps flag, write-zero clears it
    wr_reg(2'd2, 32'h0000_0120);
    rd_reg(2'd2, "R7 flag kept");
    wr_reg(2'd2, 32'h0000_0020);
    rd_reg(2'd2, "R7 flag cleared");
    // R11 stopped channel
    @(negedge clk); run_en = 0;
    wr_reg(2'd1, 32'd1);
    for (int k = 0; k < 60; k++) rd_reg(2'd1, "R11 frozen");
    // R5 reload write takes effect at next underflow
    @(negedge clk); run_en = 1;
    wr_reg(2'd0, 32'd7);
    for (int k = 0; k < 30; k++) rd_reg(2'd1, "R5 new reload");

    // Random phase
    for (int it = 0; it < 4000; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: wr_reg(2'd0, $urandom_range(0, 12));
        1: wr_reg(2'd1, $urandom_range(0, 12));
        2: wr_reg(2'd2, {23'd0, 1'($urandom_range(0, 1)), 2'b00,
                         1'($urandom_range(0, 1)), 2'b00, 3'($urandom_range(0, 1))});
        3: begin @(negedge clk); run_en = ($urandom_range(0, 3) != 0); end
        4: rd_reg(2'd0, "R5 reload read");
        5, 6: rd_reg(2'd1, "R4 count read");
        7: rd_reg(2'd2, "R6 control read");
        default: idle(1);
      endcase
    end

    // R10 capture access
    do_reset();
    wr_reg(2'd3, 32'h1234_5678);
    rd_reg(2'd3, "R10 capture reads 0");
    rd_reg(2'd0, "R10 reload untouched");
    rd_reg(2'd1, "R10 counter untouched");
    idle(1);
    check("R10 err set", {31'd0, cfg_err}, 32'd1);
    // R9 illegal rate code
    do_reset();
    wr_reg(2'd2, 32'h0000_0005);
    idle(2);
    check("R9 rate 5 err", {31'd0, cfg_err}, 32'd1);
    // R9 reserved high bit
    do_reset();
    wr_reg(2'd2, 32'h0000_1000);
    idle(2);
    check("R9 reserved bit err", {31'd0, cfg_err}, 32'd1);
    // R9 legal write leaves err low; R6 bits 8,9 not stored
    do_reset();
    wr_reg(2'd2, 32'h0000_0024);
    rd_reg(2'd2, "R6 stored control");
    idle(2);
    check("R9 legal no err", {31'd0, cfg_err}, 32'd0);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule